// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block caches recent virtual-to-physical page translations so that a load/store unit can relocate an address without walking the page tables. It is fully associative. Every entry carries a process tag, so translations belonging to several address spaces can coexist and a switch of the running process needs no flush. An entry may also be marked shared across all processes, in which case its process tag is ignored on lookup.

The lookup side is purely combinational: the requester presents a virtual page number, its process tag and whether the access is a store, and in the same cycle gets back a hit, a miss or a protection fault, together with the physical page number and the page attributes. After a miss, the walker or the trap handler writes the translation through the fill port. Maintenance software uses the page invalidate command after it edits a page-table entry. It uses the flush command to drop every translation, and may choose to keep the shared ones.

Top module: `asid_tlb`

## Requirements
- R1: An entry matches a lookup only when it is valid, its virtual page number equals `lk_vpn`, and either its process tag equals `lk_asid` or its shared flag is set.
- R2: When `lk_req` is high and a load matches, `lk_hit` is 1 in the same cycle, and `lk_ppn`, `lk_nocache` and `lk_writable` carry the matched entry's fields.
- R3: When `lk_req` is high and no entry matches, `lk_miss` is 1, `lk_hit` and `lk_fault` are 0, and `lk_ppn` is 0. When `lk_req` is low, all three flags are 0.
- R4: A store (`lk_store`=1) that matches an entry whose writable bit is 0 gives `lk_fault`=1 and `lk_hit`=0. A load to the same entry gives a hit. A store to a writable entry gives a hit.
- R5: A fill whose virtual page number and process tag equal those of a valid entry overwrites that entry. No second copy is made, so the cache loses no capacity.
- R6: A fill with no exact match goes to the lowest-indexed invalid entry when one exists.
- R7: When all entries are valid and there is no exact match, a fill replaces the entry at a rotating pointer. The pointer is 0 after reset, moves up by one (wrapping at the entry count) on each such replacement, and does not change otherwise.
- R8: A page invalidate clears every entry whose virtual page number equals `inv_vpn`, whatever its process tag or shared flag.
- R9: A flush with `flush_keep_global`=0 clears every entry. With `flush_keep_global`=1, shared entries are kept and all others are cleared.
- R10: When several commands are raised in one cycle, flush wins over invalidate, and invalidate wins over fill. The losing commands have no effect.
- R11: After reset no entry is valid, so every lookup misses.
- R12: When several entries match one lookup, the lowest-indexed one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request qualifier |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Process tag of the requester |
| lk_store | input | 1 | 1 = store access, 0 = load |
| lk_hit | output | 1 | Usable translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids the store |
| lk_ppn | output | 20 | Physical page number of the matched entry, 0 otherwise |
| lk_nocache | output | 1 | Non-cacheable attribute of the matched entry |
| lk_writable | output | 1 | Writable attribute of the matched entry |
| fl_en | input | 1 | Fill command |
| fl_vpn | input | 20 | Fill virtual page number |
| fl_asid | input | 8 | Fill process tag |
| fl_ppn | input | 20 | Fill physical page number |
| fl_nocache | input | 1 | Fill non-cacheable attribute |
| fl_writable | input | 1 | Fill writable attribute |
| fl_global | input | 1 | Fill shared flag |
| inv_en | input | 1 | Page invalidate command |
| inv_vpn | input | 20 | Page to invalidate |
| flush_en | input | 1 | Flush command |
| flush_keep_global | input | 1 | Keep shared entries on flush |

## Verification
Nearly every internal fault reaches the ports through a lookup issued one cycle after the command. A bad valid bit after an invalidate or a flush shows up as a stale hit. A wrongly chosen fill slot shows up later: a translation that should still be resident misses, or an evicted one still hits. A drifting rotating pointer evicts the wrong victim, and that is only visible once the cache is full and a few more fills have gone in. For this reason the bench tracks exact slot occupancy through whole fill sequences and does not stop at single fills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_FILL  = 2'd1,
    CMD_INVAL = 2'd2,
    CMD_FLUSH = 2'd3
  } tlb_cmd_e;

  // Flush beats invalidate, invalidate beats fill.
  function automatic tlb_cmd_e pick_cmd(input logic flush, input logic inval,
                                        input logic fill);
    if (flush)      return CMD_FLUSH;
    else if (inval) return CMD_INVAL;
    else if (fill)  return CMD_FILL;
    else            return CMD_IDLE;
  endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0]             glob,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  input  logic                     use_asid,
  input  logic                     use_global,
  output logic [N-1:0]             match
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic tag_ok;
    assign tag_ok   = !use_asid || (asid[i] == key_asid) || (use_global && glob[i]);
    assign match[i] = valid[i] && (vpn[i] == key_vpn) && tag_ok;
  end

endmodule

// File: rtl/tlb_pick_low.sv
module tlb_pick_low #(
  parameter int N    = 16,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    vec,
  output logic            any,
  output logic [IDXW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N    = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_go,
  input  logic [N-1:0]    same_vec,
  input  logic [N-1:0]    valid,
  output logic [IDXW-1:0] victim
);

  function automatic logic [IDXW-1:0] step_ptr(input logic [IDXW-1:0] p);
    return (int'(p) == N - 1) ? '0 : p + 1'b1;
  endfunction

  logic            same_any, free_any;
  logic [IDXW-1:0] same_idx, free_idx;
  logic [IDXW-1:0] rr_ptr;
  logic            rr_evict;

  tlb_pick_low #(.N(N), .IDXW(IDXW)) u_same (
    .vec(same_vec), .any(same_any), .idx(same_idx));

  tlb_pick_low #(.N(N), .IDXW(IDXW)) u_free (
    .vec(~valid), .any(free_any), .idx(free_idx));

  assign victim   = same_any ? same_idx : (free_any ? free_idx : rr_ptr);
  assign rr_evict = fill_go && !same_any && !free_any;

  always_ff @(posedge clk) begin
    if (!rst_n)        rr_ptr <= '0;
    else if (rr_evict) rr_ptr <= step_ptr(rr_ptr);
  end

  // R5: the overwrite rule keeps exact tags unique
  assert_no_dup_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(same_vec));

  assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rr_evict |=> rr_ptr == step_ptr($past(rr_ptr)));

  assert_rr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_evict |=> $stable(rr_ptr));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_nocache,
  output logic              lk_writable,
  input  logic              fl_en,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic              fl_nocache,
  input  logic              fl_writable,
  input  logic              fl_global,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush_en,
  input  logic              flush_keep_global
);
  import tlb_pkg::*;

  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             e_valid, e_glob, e_nc, e_wr;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;

  logic [ENTRIES-1:0] lk_match, fl_same, inv_match;
  logic               lk_any;
  logic [IDXW-1:0]    lk_sel, victim;
  tlb_cmd_e           cmd;
  logic               fill_go;

  assign cmd     = pick_cmd(flush_en, inv_en, fl_en);
  assign fill_go = (cmd == CMD_FILL);

  tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
    .valid(e_valid), .glob(e_glob), .vpn(e_vpn), .asid(e_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .use_asid(1'b1), .use_global(1'b1),
    .match(lk_match));

  tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_cmp (
    .valid(e_valid), .glob(e_glob), .vpn(e_vpn), .asid(e_asid),
    .key_vpn(fl_vpn), .key_asid(fl_asid), .use_asid(1'b1), .use_global(1'b0),
    .match(fl_same));

  tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv_cmp (
    .valid(e_valid), .glob(e_glob), .vpn(e_vpn), .asid(e_asid),
    .key_vpn(inv_vpn), .key_asid('0), .use_asid(1'b0), .use_global(1'b0),
    .match(inv_match));

  tlb_pick_low #(.N(ENTRIES), .IDXW(IDXW)) u_lk_pick (
    .vec(lk_match & {ENTRIES{lk_req}}), .any(lk_any), .idx(lk_sel));

  tlb_victim #(.N(ENTRIES), .IDXW(IDXW)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_go(fill_go), .same_vec(fl_same),
    .valid(e_valid), .victim(victim));

  // Lookup result, combinational
  assign lk_fault    = lk_any && lk_store && !e_wr[lk_sel];
  assign lk_hit      = lk_any && !lk_fault;
  assign lk_miss     = lk_req && !lk_any;
  assign lk_ppn      = lk_any ? e_ppn[lk_sel] : '0;
  assign lk_nocache  = lk_any && e_nc[lk_sel];
  assign lk_writable = lk_any && e_wr[lk_sel];

  // Entry storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_glob  <= '0;
      e_nc    <= '0;
      e_wr    <= '0;
      e_vpn   <= '0;
      e_asid  <= '0;
      e_ppn   <= '0;
    end else begin
      unique case (cmd)
        CMD_FLUSH: e_valid <= flush_keep_global ? (e_valid & e_glob) : '0;
        CMD_INVAL: e_valid <= e_valid & ~inv_match;
        CMD_FILL: begin
          e_valid[victim] <= 1'b1;
          e_glob[victim]  <= fl_global;
          e_nc[victim]    <= fl_nocache;
          e_wr[victim]    <= fl_writable;
          e_vpn[victim]   <= fl_vpn;
          e_asid[victim]  <= fl_asid;
          e_ppn[victim]   <= fl_ppn;
        end
        default: ;
      endcase
    end
  end

  assert_fault_is_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_store && !lk_writable);

  assert_fill_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !inv_en && !flush_en) |=>
      (!(lk_req && lk_vpn == $past(fl_vpn) && lk_asid == $past(fl_asid)) || lk_hit || lk_fault));

  assert_no_stale_after_inval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush_en) |=> (!(lk_req && lk_vpn == $past(inv_vpn)) || lk_miss));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !flush_keep_global) |=> (e_valid == '0));

  assert_flush_keeps_shared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && flush_keep_global) |=> (e_valid == $past(e_valid & e_glob)));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}) && (lk_req || !(lk_hit || lk_miss || lk_fault)));

endmodule

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0, lk_store = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_miss, lk_fault, lk_nocache, lk_writable;
  logic [19:0] lk_ppn;
  logic        fl_en = 1'b0, fl_nocache = 1'b0, fl_writable = 1'b0, fl_global = 1'b0;
  logic [19:0] fl_vpn = '0, fl_ppn = '0;
  logic [7:0]  fl_asid = '0;
  logic        inv_en = 1'b0, flush_en = 1'b0, flush_keep_global = 1'b0;
  logic [19:0] inv_vpn = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asid_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_store(lk_store),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
    .lk_nocache(lk_nocache), .lk_writable(lk_writable),
    .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_ppn(fl_ppn),
    .fl_nocache(fl_nocache), .fl_writable(fl_writable), .fl_global(fl_global),
    .inv_en(inv_en), .inv_vpn(inv_vpn),
    .flush_en(flush_en), .flush_keep_global(flush_keep_global));

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                          input logic nc, input logic wr, input logic g);
    fl_vpn = v; fl_asid = a; fl_ppn = p;
    fl_nocache = nc; fl_writable = wr; fl_global = g; fl_en = 1'b1;
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                         input logic nc, input logic wr, input logic g);
    @(negedge clk);
    set_fill(v, a, p, nc, wr, g);
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic do_inv(input logic [19:0] v);
    @(negedge clk);
    inv_vpn = v; inv_en = 1'b1;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic do_flush(input logic keep);
    @(negedge clk);
    flush_keep_global = keep; flush_en = 1'b1;
    @(negedge clk);
    flush_en = 1'b0;
  endtask

  // Lookup, sampled well away from any clock edge
  task automatic chk(input string req, input logic [19:0] v, input logic [7:0] a,
                     input logic st, input logic eh, input logic em, input logic ef,
                     input logic [19:0] ep);
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_asid = a; lk_store = st;
    #2;
    checks++;
    if ({lk_hit, lk_miss, lk_fault} !== {eh, em, ef} || lk_ppn !== ep) begin
      errors++;
      $display("FAIL %s vpn=%h asid=%h st=%0b: hit/miss/fault=%b%b%b ppn=%h, expected %b%b%b ppn=%h",
               req, v, a, st, lk_hit, lk_miss, lk_fault, lk_ppn, eh, em, ef, ep);
    end
    lk_req = 1'b0;
  endtask

  task automatic chk_attr(input string req, input logic enc, input logic ewr);
    checks++;
    lk_req = 1'b1;
    #1;
    if (lk_nocache !== enc || lk_writable !== ewr) begin
      errors++;
      $display("FAIL %s attr nc/wr=%b%b, expected %b%b", req, lk_nocache, lk_writable, enc, ewr);
    end
    lk_req = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R11", 20'h00000, 8'h00, 1'b0, 0, 1, 0, 20'h0);
    chk("R11", 20'h12345, 8'h07, 1'b1, 0, 1, 0, 20'h0);
    @(negedge clk);
    lk_vpn = 20'h12345; #2;
    checks++;
    if ({lk_hit, lk_miss, lk_fault} !== 3'b000) begin
      errors++;
      $display("FAIL R3 idle flags=%b%b%b, expected 000", lk_hit, lk_miss, lk_fault);
    end
  endtask

  task automatic t_tag_match();
    do_reset();
    do_fill(20'h00007, 8'h04, 20'h00011, 1'b0, 1'b1, 1'b0);
    chk("R2", 20'h00007, 8'h04, 1'b0, 1, 0, 0, 20'h00011);
    chk("R1", 20'h00007, 8'h05, 1'b0, 0, 1, 0, 20'h0);
    do_fill(20'h00008, 8'h04, 20'h00022, 1'b0, 1'b1, 1'b1);
    chk("R1", 20'h00008, 8'h09, 1'b0, 1, 0, 0, 20'h00022);
    chk("R3", 20'h00009, 8'h04, 1'b0, 0, 1, 0, 20'h0);
  endtask

  task automatic t_protection();
    do_reset();
    do_fill(20'h0000B, 8'h01, 20'h000B0, 1'b1, 1'b0, 1'b0);
    chk("R4", 20'h0000B, 8'h01, 1'b0, 1, 0, 0, 20'h000B0);
    lk_vpn = 20'h0000B; lk_asid = 8'h01; lk_store = 1'b0;
    chk_attr("R2", 1'b1, 1'b0);
    chk("R4", 20'h0000B, 8'h01, 1'b1, 0, 0, 1, 20'h000B0);
    do_fill(20'h0000C, 8'h01, 20'h000C0, 1'b0, 1'b1, 1'b0);
    chk("R4", 20'h0000C, 8'h01, 1'b1, 1, 0, 0, 20'h000C0);
  endtask

  task automatic t_overwrite();
    do_reset();
    do_fill(20'h00010, 8'h02, 20'h0AAAA, 1'b0, 1'b1, 1'b0);
    do_fill(20'h00010, 8'h02, 20'h0BBBB, 1'b0, 1'b1, 1'b0);
    chk("R5", 20'h00010, 8'h02, 1'b0, 1, 0, 0, 20'h0BBBB);
    for (int i = 0; i < 15; i++)
      do_fill(20'h00020 + 20'(i), 8'h02, 20'h00100 + 20'(i), 1'b0, 1'b1, 1'b0);
    chk("R5", 20'h00010, 8'h02, 1'b0, 1, 0, 0, 20'h0BBBB);
    chk("R5", 20'h0002E, 8'h02, 1'b0, 1, 0, 0, 20'h0010E);
  endtask

  task automatic t_replacement();
    do_reset();
    for (int i = 0; i < 16; i++)
      do_fill(20'h00100 + 20'(i), 8'h01, 20'h01000 + 20'(i), 1'b0, 1'b1, 1'b0);
    chk("R6", 20'h0010F, 8'h01, 1'b0, 1, 0, 0, 20'h0100F);
    do_fill(20'h00200, 8'h01, 20'h02000, 1'b0, 1'b1, 1'b0);   // evicts slot 0
    chk("R7", 20'h00100, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    chk("R7", 20'h00101, 8'h01, 1'b0, 1, 0, 0, 20'h01001);
    do_fill(20'h00201, 8'h01, 20'h02001, 1'b0, 1'b1, 1'b0);   // evicts slot 1
    chk("R7", 20'h00101, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    do_inv(20'h00105);                                       // frees slot 5
    do_fill(20'h00300, 8'h01, 20'h03000, 1'b0, 1'b1, 1'b0);   // into slot 5
    do_fill(20'h00301, 8'h01, 20'h03001, 1'b0, 1'b1, 1'b0);   // evicts slot 2
    chk("R6", 20'h00300, 8'h01, 1'b0, 1, 0, 0, 20'h03000);
    chk("R7", 20'h00102, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    chk("R7", 20'h00103, 8'h01, 1'b0, 1, 0, 0, 20'h01003);
    chk("R7", 20'h00301, 8'h01, 1'b0, 1, 0, 0, 20'h03001);
  endtask

  task automatic t_multi_match_inval();
    do_reset();
    do_fill(20'h0000A, 8'h00, 20'h00031, 1'b0, 1'b1, 1'b1);
    do_fill(20'h0000A, 8'h03, 20'h00032, 1'b0, 1'b1, 1'b0);
    chk("R12", 20'h0000A, 8'h03, 1'b0, 1, 0, 0, 20'h00031);
    do_inv(20'h0000A);
    chk("R8", 20'h0000A, 8'h03, 1'b0, 0, 1, 0, 20'h0);
    chk("R8", 20'h0000A, 8'h07, 1'b0, 0, 1, 0, 20'h0);
  endtask

  task automatic t_flush();
    do_reset();
    do_fill(20'h0000C, 8'h01, 20'h000C1, 1'b0, 1'b1, 1'b1);
    do_fill(20'h0000D, 8'h01, 20'h000D1, 1'b0, 1'b1, 1'b0);
    do_flush(1'b1);
    chk("R9", 20'h0000C, 8'h05, 1'b0, 1, 0, 0, 20'h000C1);
    chk("R9", 20'h0000D, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    do_flush(1'b0);
    chk("R9", 20'h0000C, 8'h05, 1'b0, 0, 1, 0, 20'h0);
  endtask

  task automatic t_priority();
    do_reset();
    do_fill(20'h00040, 8'h01, 20'h00400, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    set_fill(20'h00041, 8'h01, 20'h00410, 1'b0, 1'b1, 1'b0);
    flush_keep_global = 1'b0; flush_en = 1'b1;
    @(negedge clk);
    fl_en = 1'b0; flush_en = 1'b0;
    chk("R10", 20'h00040, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    chk("R10", 20'h00041, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    do_fill(20'h00050, 8'h01, 20'h00500, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    set_fill(20'h00051, 8'h01, 20'h00510, 1'b0, 1'b1, 1'b0);
    inv_vpn = 20'h00050; inv_en = 1'b1;
    @(negedge clk);
    fl_en = 1'b0; inv_en = 1'b0;
    chk("R10", 20'h00050, 8'h01, 1'b0, 0, 1, 0, 20'h0);
    chk("R10", 20'h00051, 8'h01, 1'b0, 0, 1, 0, 20'h0);
  endtask

  initial begin
    t_reset_state();
    t_tag_match();
    t_protection();
    t_overwrite();
    t_replacement();
    t_multi_match_inval();
    t_flush();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (R1..R12 run incomplete): timed out, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule